// File: doc/BRIEF.md
# GPIO Grouped Interrupt Controller

This block turns activity on a wide set of general-purpose input pins into a single interrupt request. The pins are organised as ports of 32 bits, each port split into four byte lanes. Eight interrupt groups exist. Group g can watch bit g of any one byte lane, so a pin whose index within its port is n can only ever serve group n mod 8. Software chooses the lane for each group, a trigger mode for each group, and a per-group enable. It reads back raw and enabled pending state and clears latched events by writing ones to an acknowledge register.

Raw pins are asynchronous and pass through a two-flop synchroniser before any detection. Edge modes latch a sticky pending bit. Level modes report the live level, so an acknowledge cannot hold them clear while the level remains. A software mode forces the pending bit on, which lets firmware raise the request without any pin activity. The register port is a plain single-cycle bus: a write takes effect on the clock edge where it is asserted, read data is combinational from the address, and no back-pressure exists. No part of the interface is a stream, so no valid/ready handshake is used.

Top module: `gpio_grp_irq`

## Requirements
- R1: After reset the mode (0x78), lane-select (0x7C) and enable (0x80) registers read zero, raw pending (0x88) and enabled pending (0x8C) read zero, and `irq` is low.
- R2: The mode register holds a 3-bit field per group at bits [3g+2:3g]. The encodings are 1 active-high level, 2 active-low level, 3 software set, 5 rising edge, 6 falling edge, and 7 either edge.
- R3: The lane-select register holds a 4-bit field per group at bits [4g+3:4g], with value 4*port+lane. Group g watches pin index field*8+g, and no other pin affects it.
- R4: In level modes the pending bit of a group follows the synchronised pin level: the level itself for mode 1 and its inverse for mode 2. The pin level shows in raw pending three clock edges after the pin changes. An acknowledge has no lasting effect while the level holds.
- R5: In edge modes a matching transition of the synchronised pin sets a pending bit. That bit stays set until it is acknowledged.
- R6: Writing 1 to bit g of the acknowledge register (0x84) clears group g's latched edge. Writing 0 leaves it unchanged.
- R7: When an acknowledge and a new qualifying edge reach a group on the same clock edge, the pending bit stays set.
- R8: Mode 3 holds the group's pending bit at 1.
- R9: Raw pending is read at 0x88 bits [7:0]. Enabled pending at 0x8C reads raw pending AND the enable register.
- R10: `irq` is high exactly when any enabled pending bit is set.
- R11: Configuration registers read back what was written within their widths: 24 bits for modes, 32 for lane select, 8 for enables. The acknowledge offset and all unmapped offsets read zero.
- R12: Modes 0 and 4 clear the group's pending bit and ignore its pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, acts on the rising clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pins | input | 128 | Raw asynchronous pin levels, port-major |
| irq | output | 1 | Combined interrupt request |

## Verification
Several properties are checked on every cycle inside each group:
- software-set mode forces the pending bit;
- the off modes clear it;
- a latched edge survives until an acknowledge;
- an acknowledge without a coinciding edge clears it.

The top level checks on every cycle that the request never rises while every enable bit is zero.

Some behaviour only the bench scenarios can show:
- that the lane selector reaches the intended pin and no neighbour;
- that the synchroniser latency is three edges;
- that level modes re-assert after an acknowledge;
- that an edge arriving together with an acknowledge wins.

// File: rtl/gpi_pkg.sv
package gpi_pkg;
  localparam int GRP_N   = 8;
  localparam int MODE_W  = 3;
  localparam int SEL_W   = 4;
  localparam int PORT_W  = 32;

  localparam int OFF_MODE  = 'h78;
  localparam int OFF_SEL   = 'h7C;
  localparam int OFF_EN    = 'h80;
  localparam int OFF_ACK   = 'h84;
  localparam int OFF_RAW   = 'h88;
  localparam int OFF_MASKD = 'h8C;

  typedef enum logic [MODE_W-1:0] {
    TRG_OFF  = 3'd0,
    TRG_HIGH = 3'd1,
    TRG_LOW  = 3'd2,
    TRG_SOFT = 3'd3,
    TRG_RSV  = 3'd4,
    TRG_RISE = 3'd5,
    TRG_FALL = 3'd6,
    TRG_BOTH = 3'd7
  } trig_e;
endpackage

// File: rtl/gpi_sync.sv
module gpi_sync #(
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      d_sync <= '0;
    end else begin
      meta_q <= d_async;
      d_sync <= meta_q;
    end
  end
endmodule

// File: rtl/gpi_group.sv
module gpi_group
  import gpi_pkg::*;
#(
  parameter int NPINS = 128,
  parameter int GIDX  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_s,
  input  logic [SEL_W-1:0] sel,
  input  trig_e            mode,
  input  logic             ack,
  output logic             pend
);
  localparam int LANE_BITS = $clog2(GRP_N);
  localparam int IDX_W     = SEL_W + LANE_BITS;

  logic [IDX_W-1:0] src_idx;
  logic             cur;
  logic             prev_q;
  logic             rise, fall, trig;
  logic             pend_d;

  assign src_idx = {sel, LANE_BITS'(GIDX)};
  assign cur     = (int'(src_idx) < NPINS) ? pins_s[src_idx] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;

  always_comb begin
    case (mode)
      TRG_RISE: trig = rise;
      TRG_FALL: trig = fall;
      TRG_BOTH: trig = rise | fall;
      default:  trig = 1'b0;
    endcase
  end

  always_comb begin
    case (mode)
      TRG_HIGH:                   pend_d = cur;
      TRG_LOW:                    pend_d = ~cur;
      TRG_SOFT:                   pend_d = 1'b1;
      TRG_RISE, TRG_FALL, TRG_BOTH: pend_d = (pend & ~ack) | trig;
      default:                    pend_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end

  // R8
  p_soft_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRG_SOFT) |=> pend);

  // R12
  p_off_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRG_OFF || mode == TRG_RSV) |=> !pend);

  // R5
  p_edge_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == TRG_RISE || mode == TRG_FALL || mode == TRG_BOTH) && pend && !ack) |=> pend);

  // R6
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == TRG_RISE || mode == TRG_FALL || mode == TRG_BOTH) && ack && !trig) |=> !pend);

  // R7
  p_edge_beats_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && ack) |=> pend);
endmodule

// File: rtl/gpio_grp_irq.sv
module gpio_grp_irq
  import gpi_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wr_en,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pins,
  output logic                        irq
);
  localparam int NPINS    = NUM_PORTS * PORT_W;
  localparam int MODE_TOT = GRP_N * MODE_W;
  localparam int SEL_TOT  = GRP_N * SEL_W;

  logic [MODE_TOT-1:0] mode_q;
  logic [SEL_TOT-1:0]  sel_q;
  logic [GRP_N-1:0]    en_q;
  logic [GRP_N-1:0]    ack_p;
  logic [GRP_N-1:0]    pend;
  logic [GRP_N-1:0]    pend_en;
  logic [NPINS-1:0]    pins_s;

  logic hit_mode, hit_sel, hit_en, hit_ack, hit_raw, hit_maskd;

  assign hit_mode  = (addr == ADDR_W'(OFF_MODE));
  assign hit_sel   = (addr == ADDR_W'(OFF_SEL));
  assign hit_en    = (addr == ADDR_W'(OFF_EN));
  assign hit_ack   = (addr == ADDR_W'(OFF_ACK));
  assign hit_raw   = (addr == ADDR_W'(OFF_RAW));
  assign hit_maskd = (addr == ADDR_W'(OFF_MASKD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      sel_q  <= '0;
      en_q   <= '0;
    end else if (wr_en) begin
      if (hit_mode) mode_q <= wdata[MODE_TOT-1:0];
      if (hit_sel)  sel_q  <= wdata[SEL_TOT-1:0];
      if (hit_en)   en_q   <= wdata[GRP_N-1:0];
    end
  end

  assign ack_p = (wr_en && hit_ack) ? wdata[GRP_N-1:0] : '0;

  gpi_sync #(.WIDTH(NPINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(pins),
    .d_sync (pins_s)
  );

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    gpi_group #(.NPINS(NPINS), .GIDX(g)) u_grp (
      .clk   (clk),
      .rst_n (rst_n),
      .pins_s(pins_s),
      .sel   (sel_q[g*SEL_W +: SEL_W]),
      .mode  (trig_e'(mode_q[g*MODE_W +: MODE_W])),
      .ack   (ack_p[g]),
      .pend  (pend[g])
    );
  end

  assign pend_en = pend & en_q;
  assign irq     = |pend_en;

  always_comb begin
    rdata = '0;
    if (hit_mode)       rdata = DATA_W'(mode_q);
    else if (hit_sel)   rdata = DATA_W'(sel_q);
    else if (hit_en)    rdata = DATA_W'(en_q);
    else if (hit_raw)   rdata = DATA_W'(pend);
    else if (hit_maskd) rdata = DATA_W'(pend_en);
  end

  // R10
  p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != '0));
endmodule

// File: tb/gpio_grp_irq_bench.sv
`timescale 1ns/1ps
module gpio_grp_irq_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   addr = '0;
  logic         wr_en = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [127:0] pins = '0;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_grp_irq u_gpio_grp_irq (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .pins(pins), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic [127:0] v);
    @(negedge clk);
    pins = v;
  endtask

  function automatic bit e_low(input int m);
    return (m == 2 || m == 3);
  endfunction
  function automatic bit e_up(input int m);
    return (m == 1 || m == 3 || m == 5 || m == 7);
  endfunction
  function automatic bit e_acked(input int m);
    return (m == 1 || m == 3);
  endfunction
  function automatic bit e_down(input int m);
    return (m == 2 || m == 3 || m == 6 || m == 7);
  endfunction
  function automatic string tag(input int m);
    if (m == 0 || m == 4) return "R12";
    if (m == 1 || m == 2) return "R4";
    if (m == 3) return "R8";
    return "R5";
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(8'h78, v); chk("R1 mode", v, 0);
    rd(8'h7C, v); chk("R1 sel", v, 0);
    rd(8'h80, v); chk("R1 en", v, 0);
    rd(8'h88, v); chk("R1 raw", v, 0);
    rd(8'h8C, v); chk("R1 maskd", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R11 readback and unmapped
    wr(8'h78, 32'hFFABCDEF); rd(8'h78, v); chk("R11 mode", v, 32'h00ABCDEF);
    wr(8'h7C, 32'h12345678); rd(8'h7C, v); chk("R11 sel", v, 32'h12345678);
    wr(8'h80, 32'h5A5A5AA5); rd(8'h80, v); chk("R11 en", v, 32'h000000A5);
    rd(8'h84, v); chk("R11 ack reads 0", v, 0);
    rd(8'h00, v); chk("R11 unmapped 00", v, 0);
    rd(8'h90, v); chk("R11 unmapped 90", v, 0);
    rd(8'h7A, v); chk("R11 unmapped 7A", v, 0);
    wr(8'h78, 0); wr(8'h7C, 0); wr(8'h80, 0);

    // Sweep every group over every mode (R2, R3)
    for (int g = 0; g < 8; g++) begin
      for (int m = 0; m < 8; m++) begin
        int sel, tgt;
        logic [7:0] mk, rawx, mskx;
        logic [127:0] decoy;
        sel = (g * 5 + m * 3) % 16;
        tgt = sel * 8 + g;
        mk = ((g + m) % 2 == 1) ? 8'(1 << g) : ~8'(1 << g);
        drive('0); idle(4);
        wr(8'h7C, 32'(sel) << (4 * g));
        wr(8'h78, 32'(m) << (3 * g));
        wr(8'h80, {24'd0, mk});
        idle(4);
        wr(8'h84, 32'hFF); idle(2);
        rd(8'h88, v); chk($sformatf("R2 %s g%0d m%0d idle", tag(m), g, m), v, 32'(e_low(m)) << g);

        decoy = ~(128'd1 << tgt);
        drive(decoy); idle(4);
        rd(8'h88, v); chk($sformatf("R3 g%0d m%0d decoys", g, m), v, 32'(e_low(m)) << g);

        drive(decoy | (128'd1 << tgt)); idle(4);
        rawx = 8'(e_up(m)) << g;
        mskx = rawx & mk;
        rd(8'h88, v); chk($sformatf("%s g%0d m%0d up", tag(m), g, m), v, {24'd0, rawx});
        rd(8'h8C, v); chk($sformatf("R9 g%0d m%0d", g, m), v, {24'd0, mskx});
        chk($sformatf("R10 g%0d m%0d", g, m), {31'd0, irq}, {31'd0, |mskx});

        wr(8'h84, 32'h0); idle(1);
        rd(8'h88, v); chk($sformatf("R6 zero ack g%0d m%0d", g, m), v, {24'd0, rawx});

        wr(8'h84, 32'(1 << g)); idle(2);
        rd(8'h88, v); chk($sformatf("R6 %s g%0d m%0d acked", tag(m), g, m), v, 32'(e_acked(m)) << g);

        drive(decoy); idle(4);
        rd(8'h88, v); chk($sformatf("%s g%0d m%0d down", tag(m), g, m), v, 32'(e_down(m)) << g);
      end
    end

    // R7 edge and acknowledge on the same edge
    drive('0);
    wr(8'h7C, 0); wr(8'h78, 32'd5); wr(8'h80, 32'd1);
    idle(4); wr(8'h84, 32'hFF); idle(2);
    drive(128'd1);
    @(negedge clk);
    wr(8'h84, 32'd1);
    rd(8'h88, v); chk("R7 edge wins", v, 32'd1);
    wr(8'h84, 32'd1); idle(1);
    rd(8'h88, v); chk("R6 later ack clears", v, 32'd0);

    // R10 every enable pattern with all groups in soft mode
    begin
      logic [31:0] allsoft;
      allsoft = 0;
      for (int g = 0; g < 8; g++) allsoft |= 32'(3) << (3 * g);
      wr(8'h78, allsoft); idle(2);
    end
    for (int mk = 0; mk < 256; mk++) begin
      wr(8'h80, 32'(mk));
      rd(8'h8C, v); chk("R9 maskd sweep", v, 32'(mk));
      chk("R10 irq sweep", {31'd0, irq}, {31'd0, mk != 0});
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule